// File: doc/BRIEF.md
# Programmable Reload Timer with Event Input

This block is a 16-bit down-counter that a CPU programs through a small byte-wide register window. The counter is driven by one of three selectable sources. The first is the system clock divided by a programmable prescaler. The second is an external event pin, which turns the block into an event counter. The third is a slow real-time clock signal. The event and real-time clock inputs are captured and edge-qualified inside the block, and each has a fixed latency.

When the count falls to zero, the block raises an interrupt request. The request stays high until software reads the control register. In continuous mode the counter reloads from a 16-bit reload register on the next cycle and keeps running. In single-pass mode it parks at zero and drops its own enable bit. An optional output pin toggles on every end-of-count. In continuous mode this gives a square wave whose period is twice the timeout.

Registers are selected by a 2-bit address. Address 0 is the control register. Addresses 1 and 2 take the reload low and high bytes on a write, and return the current count low byte and the latched high byte on a read. Address 3 is the source select.

Top module: `prt_timer`

## Requirements
- R1: After reset, the count, the control register, the source select, the interrupt request and the toggle output all read 0. A source select of 0 means the prescaled system clock.
- R2: The control register fields are:
  - bit 0: enable
  - bit 1: restart, which is write-only and reads 0
  - bits 3:2: prescale select, where 0, 1, 2, 3 divide by 4, 16, 64, 256
  - bit 4: continuous mode
  - bit 5: output enable
  - bit 7: interrupt flag, read-only

  A write with bit 1 set loads the count from the reload register at that write edge and clears the prescaler. With the system clock as the source, the count then falls by one every D cycles, and the first decrement happens D clock edges after the write edge.
- R3: When a decrement takes the count from 1 to 0, the interrupt flag (control bit 7) and irqOut go high on that same edge.
- R4: A read of the control register (address 0) returns the flag and clears it, and irqOut with it, on the read edge. If a new end-of-count falls on the same edge, the flag stays set.
- R5: In continuous mode (bit 4 set), the cycle after the count reaches 0 the count reloads from the reload register and counting continues.
- R6: In single-pass mode (bit 4 clear), the count stays at 0 after end-of-count and control bit 0 clears.
- R7: Source select 1 chooses the event pin and bypasses the prescaler. Each rising edge on eventIn lowers the count by one. The new value appears on the 5th rising clock edge after the pin rises, and not before.
- R8: Source select 2 chooses the real-time clock input. Each falling edge on rtcIn lowers the count by one on the 2nd rising clock edge after the fall.
- R9: tmrOut is low while output enable (bit 5) is clear. It starts low when output enable is set, and it toggles at every end-of-count. In continuous mode its period is therefore twice the timeout.
- R10: Reading address 1 returns count bits 7:0 and captures count bits 15:8. A later read of address 2 returns the captured byte, even if the count has changed since.
- R11: Source select 3 selects no source, and the count holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regSel | input | 2 | Register address |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (read side effects happen on the edge) |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, combinational from regSel |
| eventIn | input | 1 | External event pin |
| rtcIn | input | 1 | Real-time clock signal |
| irqOut | output | 1 | Interrupt request, equal to the flag |
| tmrOut | output | 1 | Toggle output |

## Verification
The assertions assume the following about the inputs:
- Event pin edges are at least two system clocks apart, and the pin holds each level for two or more clocks.
- The real-time clock signal is slow enough that each fall is seen once.
- A continuous-mode run uses a nonzero reload value.

The bench drives eventIn and rtcIn only at falling clock edges and holds each level for at least two cycles. Random trials draw reload values from 3 to 20, so zero never reloads into a running timer.

// File: rtl/prt_pkg.sv
package prt_pkg;

  typedef enum logic [1:0] {
    SRC_SYS = 2'd0,
    SRC_EVT = 2'd1,
    SRC_RTC = 2'd2,
    SRC_OFF = 2'd3
  } srcSel_t;

  localparam logic [1:0] RA_CTRL = 2'd0;
  localparam logic [1:0] RA_LO   = 2'd1;
  localparam logic [1:0] RA_HI   = 2'd2;
  localparam logic [1:0] RA_SRC  = 2'd3;

  localparam int CB_EN      = 0;
  localparam int CB_RESTART = 1;
  localparam int CB_PRE     = 2;
  localparam int CB_CONT    = 4;
  localparam int CB_OUTEN   = 5;
  localparam int CB_FLAG    = 7;

  typedef struct packed {
    logic       enable;
    logic       restart;
    logic       contMode;
    srcSel_t    src;
    logic [1:0] preSel;
  } dpCtl_t;

endpackage

// File: rtl/prt_datapath.sv
module prt_datapath
  import prt_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           ctl,
  input  logic [CNT_W-1:0] reloadVal,
  input  logic             eventIn,
  input  logic             rtcIn,
  output logic [CNT_W-1:0] count,
  output logic             hitZero
);

  localparam int EVT_STAGES = 4;

  logic [PRE_W-1:0]      preCnt;
  logic [PRE_W-1:0]      preMask;
  logic [EVT_STAGES-1:0] evtShift;
  logic                  evtTick;
  logic                  rtcCap, rtcPrev;
  logic                  sysTick, rtcFall, tick;
  logic [CNT_W-1:0]      countQ;

  // Prescaler mask: 2^(2*(sel+1)) - 1
  always_comb preMask = PRE_W'((1 << (2 * (int'(ctl.preSel) + 1))) - 1);

  always_ff @(posedge clk) begin
    if (!rstN)                                   preCnt <= '0;
    else if (ctl.restart)                        preCnt <= '0;
    else if (ctl.enable && ctl.src == SRC_SYS)   preCnt <= preCnt + 1'b1;
  end

  assign sysTick = ((preCnt & preMask) == preMask);

  // Event path: capture, two more stages, edge detect, registered pulse
  always_ff @(posedge clk) begin
    if (!rstN) begin
      evtShift <= '0;
      evtTick  <= 1'b0;
    end else begin
      evtShift <= {evtShift[EVT_STAGES-2:0], eventIn};
      evtTick  <= evtShift[EVT_STAGES-2] & ~evtShift[EVT_STAGES-1];
    end
  end

  // RTC path: single capture, fall seen one edge later
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rtcCap  <= 1'b0;
      rtcPrev <= 1'b0;
    end else begin
      rtcCap  <= rtcIn;
      rtcPrev <= rtcCap;
    end
  end

  assign rtcFall = rtcPrev & ~rtcCap;

  always_comb begin
    unique case (ctl.src)
      SRC_SYS: tick = sysTick;
      SRC_EVT: tick = evtTick;
      SRC_RTC: tick = rtcFall;
      default: tick = 1'b0;
    endcase
    tick = tick & ctl.enable;
  end

  assign hitZero = tick && (countQ == CNT_W'(1)) && !ctl.restart;

  always_ff @(posedge clk) begin
    if (!rstN)                                             countQ <= '0;
    else if (ctl.restart)                                  countQ <= reloadVal;
    else if (ctl.enable && ctl.contMode && countQ == '0)   countQ <= reloadVal;
    else if (tick && countQ != '0)                         countQ <= countQ - 1'b1;
  end

  assign count = countQ;

  p_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.restart && !(ctl.enable && ctl.contMode && count == '0))
      |=> (count == $past(count) || count == $past(count) - CNT_W'(1)));

  p_restart_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.restart |=> count == $past(reloadVal));

  p_reload_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.enable && ctl.contMode && !ctl.restart && count == '0)
      |=> count == $past(reloadVal));

  p_src_off_r11: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.src == SRC_OFF && !ctl.restart && count != '0) |=> $stable(count));

endmodule

// File: rtl/prt_ctrl.sv
module prt_ctrl
  import prt_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regSel,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic [CNT_W-1:0]  count,
  input  logic              hitZero,
  output dpCtl_t            ctl,
  output logic [CNT_W-1:0]  reloadVal,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut,
  output logic              tmrOut
);

  logic             enReg, contReg, outEnReg, flagReg, togReg;
  logic [1:0]       preReg;
  srcSel_t          srcReg;
  logic [CNT_W-1:0] reloadReg;
  logic [DATA_W-1:0] hiHold;
  logic             wrCtrl, rdCtrl;

  assign wrCtrl = wrEn && regSel == RA_CTRL;
  assign rdCtrl = rdEn && regSel == RA_CTRL;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg     <= 1'b0;
      contReg   <= 1'b0;
      outEnReg  <= 1'b0;
      preReg    <= '0;
      srcReg    <= SRC_SYS;
      reloadReg <= '0;
    end else begin
      if (wrCtrl) begin
        enReg    <= wrData[CB_EN];
        contReg  <= wrData[CB_CONT];
        outEnReg <= wrData[CB_OUTEN];
        preReg   <= wrData[CB_PRE +: 2];
      end else if (hitZero && !contReg) begin
        enReg <= 1'b0;
      end
      if (wrEn && regSel == RA_LO)  reloadReg[DATA_W-1:0]     <= wrData;
      if (wrEn && regSel == RA_HI)  reloadReg[CNT_W-1:DATA_W] <= wrData;
      if (wrEn && regSel == RA_SRC) srcReg <= srcSel_t'(wrData[1:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagReg <= 1'b0;
      togReg  <= 1'b0;
      hiHold  <= '0;
    end else begin
      if (hitZero)     flagReg <= 1'b1;
      else if (rdCtrl) flagReg <= 1'b0;
      if (!outEnReg)   togReg  <= 1'b0;
      else if (hitZero) togReg <= ~togReg;
      if (rdEn && regSel == RA_LO) hiHold <= count[CNT_W-1:DATA_W];
    end
  end

  always_comb begin
    rdData = '0;
    unique case (regSel)
      RA_CTRL: begin
        rdData[CB_EN]       = enReg;
        rdData[CB_PRE +: 2] = preReg;
        rdData[CB_CONT]     = contReg;
        rdData[CB_OUTEN]    = outEnReg;
        rdData[CB_FLAG]     = flagReg;
      end
      RA_LO:   rdData = count[DATA_W-1:0];
      RA_HI:   rdData = hiHold;
      default: rdData[1:0] = srcReg;
    endcase
  end

  always_comb begin
    ctl.enable   = enReg;
    ctl.restart  = wrCtrl && wrData[CB_RESTART];
    ctl.contMode = contReg;
    ctl.src      = srcReg;
    ctl.preSel   = preReg;
  end

  assign reloadVal = reloadReg;
  assign irqOut    = flagReg;
  assign tmrOut    = togReg;

  p_irq_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    hitZero |=> irqOut);

  p_irq_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rdCtrl && !hitZero) |=> !irqOut);

  p_oneshot_stop_r6: assert property (@(posedge clk) disable iff (!rstN)
    (hitZero && !contReg && !wrCtrl) |=> !ctl.enable);

  p_toggle_r9: assert property (@(posedge clk) disable iff (!rstN)
    (hitZero && outEnReg && !wrCtrl) |=> tmrOut != $past(tmrOut));

endmodule

// File: rtl/prt_timer.sv
module prt_timer
  import prt_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PRE_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regSel,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              eventIn,
  input  logic              rtcIn,
  output logic              irqOut,
  output logic              tmrOut
);

  localparam int CNT_W = 2 * DATA_W;

  dpCtl_t           ctl;
  logic [CNT_W-1:0] reloadVal, count;
  logic             hitZero;

  prt_ctrl #(.DATA_W(DATA_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .regSel(regSel), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .count(count), .hitZero(hitZero), .ctl(ctl),
    .reloadVal(reloadVal), .rdData(rdData), .irqOut(irqOut), .tmrOut(tmrOut)
  );

  prt_datapath #(.CNT_W(CNT_W), .PRE_W(PRE_W)) i_datapath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reloadVal(reloadVal),
    .eventIn(eventIn), .rtcIn(rtcIn), .count(count), .hitZero(hitZero)
  );

endmodule

// File: tb/test_prt_timer.sv
module test_prt_timer;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] regSel = 2'd0;
  logic       wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] rdData;
  logic       eventIn = 1'b0, rtcIn = 1'b0;
  logic       irqOut, tmrOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  prt_timer i_prt_timer (
    .clk(clk), .rstN(rstN), .regSel(regSel), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .eventIn(eventIn), .rtcIn(rtcIn),
    .irqOut(irqOut), .tmrOut(tmrOut)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] ctrlByte(input bit en, input bit rs,
                                          input int ps, input bit cont, input bit oe);
    return {2'b00, oe, cont, 2'(ps), rs, en};
  endfunction

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    regSel = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    regSel = a; rdEn = 1'b1; #1;
    d = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    regSel = a; #1;
    d = rdData;
  endtask

  task automatic waitN(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, lo, hi;
    int rl, ps, dv, cnt, pre, flag, tog;
    void'($urandom(32'd4711));

    waitN(3);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    peek(2'd0, d); chk("R1 ctrl", d, 0);
    peek(2'd3, d); chk("R1 src", d, 0);
    peek(2'd1, d); chk("R1 count", d, 0);
    chk("R1 irq", irqOut, 0);
    chk("R1 tmrOut", tmrOut, 0);

    // R2 restart and divide-by-4 stepping
    wr(2'd1, 8'd5); wr(2'd2, 8'd0);
    wr(2'd0, ctrlByte(1, 1, 0, 0, 0));
    peek(2'd0, d); chk("R2 restart reads 0", d, 8'h01);
    for (int k = 0; k < 12; k++) begin
      peek(2'd1, d); chk("R2 div4 step", d, 5 - k / 4);
      @(negedge clk);
    end
    wr(2'd0, 8'd0);

    // R3 / R6 single pass from 3
    wr(2'd1, 8'd3);
    wr(2'd0, ctrlByte(1, 1, 0, 0, 0));
    for (int k = 0; k < 16; k++) begin
      peek(2'd1, d); chk("R6 single pass count", d, (k >= 12) ? 0 : 3 - k / 4);
      chk("R3 irq on zero", irqOut, (k >= 12) ? 1 : 0);
      @(negedge clk);
    end
    peek(2'd0, d); chk("R6 enable cleared", d[0], 0);
    chk("R3 flag bit", d[7], 1);

    // R4 read clears flag
    rd(2'd0, d); chk("R4 read returns flag", d[7], 1);
    chk("R4 irq cleared", irqOut, 0);
    peek(2'd0, d); chk("R4 flag bit cleared", d[7], 0);

    // R5 / R9 / R2 random continuous trials
    for (int it = 0; it < 6; it++) begin
      rl = 3 + int'($urandom % 18);
      ps = int'($urandom % 2);
      dv = 4 << (2 * ps);
      wr(2'd0, 8'd0);
      rd(2'd0, d);
      wr(2'd1, 8'(rl)); wr(2'd2, 8'd0);
      wr(2'd0, ctrlByte(1, 1, ps, 1, 1));
      cnt = rl; pre = 0; flag = 0; tog = 0;
      for (int k = 0; k < 2 * rl * dv + dv + 3; k++) begin
        peek(2'd1, d); chk("R5 continuous count", d, cnt);
        chk("R3 irq model", irqOut, flag);
        chk("R9 toggle model", tmrOut, tog);
        @(negedge clk);
        if (cnt == 0) begin
          cnt = rl;
          pre = (pre + 1) % dv;
        end else begin
          if (pre == dv - 1) begin
            if (cnt == 1) begin flag = 1; tog ^= 1; end
            cnt--;
          end
          pre = (pre + 1) % dv;
        end
      end
    end
    wr(2'd0, 8'd0);
    chk("R9 output off", tmrOut, 0);
    rd(2'd0, d);

    // R7 event source, prescaler bypassed (sel 3 would be /256)
    wr(2'd3, 8'd1);
    wr(2'd1, 8'd10);
    wr(2'd0, ctrlByte(1, 1, 3, 0, 0));
    for (int p = 0; p < 4; p++) begin
      eventIn = 1'b1;
      for (int e = 1; e <= 5; e++) begin
        @(negedge clk);
        peek(2'd1, d);
        if (e == 4) chk("R7 no change by edge 4", d, 10 - p);
        if (e == 5) chk("R7 decrement at edge 5", d, 9 - p);
      end
      eventIn = 1'b0;
      waitN(2 + p);
    end
    wr(2'd0, 8'd0);

    // R8 RTC source
    rtcIn = 1'b1;
    wr(2'd3, 8'd2);
    waitN(3);
    wr(2'd0, ctrlByte(1, 1, 0, 0, 0));
    for (int p = 0; p < 3; p++) begin
      rtcIn = 1'b0;
      @(negedge clk); peek(2'd1, d); chk("R8 no change at edge 1", d, 10 - p);
      @(negedge clk); peek(2'd1, d); chk("R8 decrement at edge 2", d, 9 - p);
      rtcIn = 1'b1;
      waitN(3);
    end
    wr(2'd0, 8'd0);

    // R11 no source: count holds, event pin ignored
    wr(2'd3, 8'd3);
    wr(2'd1, 8'd7);
    wr(2'd0, ctrlByte(1, 1, 0, 1, 0));
    for (int i = 0; i < 5; i++) begin
      eventIn = 1'b1; waitN(3); eventIn = 1'b0; waitN(3);
    end
    peek(2'd1, d); chk("R11 count held", d, 7);
    wr(2'd0, 8'd0);

    // R10 coherent two-byte read across a borrow
    wr(2'd3, 8'd0);
    wr(2'd1, 8'h00); wr(2'd2, 8'h01);
    wr(2'd0, ctrlByte(1, 1, 0, 0, 0));
    rd(2'd1, lo);
    waitN(4);
    peek(2'd1, d); chk("R10 live low moved", d, 8'hFF);
    rd(2'd2, hi);
    chk("R10 coherent value", {hi, lo}, 16'h0100);
    rd(2'd1, lo); rd(2'd2, hi);
    chk("R10 fresh value", {hi, lo}, 16'h00FF);
    wr(2'd0, 8'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule